// File: doc/BRIEF.md
# Two-Class Round-Robin Thread Dispatcher

This block sits between four fixed-function request sources and an array of shader cores. The sources are the vertex, geometry, pixel and media front ends. Each source holds one thread launch request on its port. A request carries a priority class, a payload length and a count of input items already buffered for it. Each cycle the dispatcher decides which requests are ready. It picks at most one of them: strictly by class, and in rotating order inside a class. The chosen thread goes to the lowest free thread slot on the lowest-numbered core that has one. The block then streams the thread's payload beats to that slot over a valid/ready channel.

Slots stay occupied until the running thread reports its end with a termination message naming its core and slot. The default build has 12 cores with 5 slots each. A single parameter selects a smaller 6-core, 4-slot build. The payload data itself lives in a shared staging buffer outside this block. The stream therefore carries the target and the beat index, and the consumer uses them to fetch and write the thread's registers.

Top module: `td_dispatch`

## Requirements
- R1: After reset all slots are free, no grant is given, `pay_valid` is low, and both class pointers rest on source 0.
- R2: A request is eligible only when its source-specific readiness holds. The source index fixes the kind: 0 vertex, 1 geometry, 2 pixel, 3 media. Every kind needs a length of at least 1. A vertex request also needs avail ≥ 2. A geometry request needs avail ≥ len. A pixel request needs len to be 2, 4 or 8 quads and avail ≥ len. A media request needs avail ≥ 1.
- R3: When any eligible high-class request (`src_high`=1) exists, no low-class request is granted.
- R4: Inside a class, the search starts at that class's pointer and rises with wrap-around. When a class grants, its pointer moves to the source after the one granted. The other class's pointer is left unchanged.
- R5: At most one source is granted per cycle, and no grant is given while a payload transfer is still in progress.
- R6: A granted thread takes the lowest-indexed core that has a free slot, and within that core its lowest free slot.
- R7: With every slot occupied, no request is granted and neither pointer moves.
- R8: In the cycle after a grant, `pay_valid` rises with beat 0. Beats run 0 to len-1, and `pay_last` is set on the final beat. Outputs hold while `pay_ready` is low, and the stream ends after the last beat is accepted.
- R9: A termination frees the named slot from the next cycle on. A termination naming a free slot, or an out-of-range core or slot, has no effect.
- R10: The default build grants exactly 60 concurrent threads (12 cores × 5 slots) before it stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 4 | Request present, one bit per source |
| src_high | input | 4 | Request class, 1 = high |
| src_avail | input | 4*AVAIL_W | Buffered input items per source, source s at bits [s*AVAIL_W +: AVAIL_W] |
| src_len | input | 4*LEN_W | Payload beats per source (quad count for pixel) |
| src_grant | output | 4 | One-hot grant in the selection cycle |
| term_valid | input | 1 | Termination message strobe |
| term_core | input | CORE_W | Core of the finishing thread |
| term_slot | input | SLOT_W | Slot of the finishing thread |
| pay_valid | output | 1 | Payload beat valid |
| pay_ready | input | 1 | Payload beat accepted |
| pay_src | output | 2 | Source of the thread being loaded |
| pay_core | output | CORE_W | Target core |
| pay_slot | output | SLOT_W | Target slot |
| pay_beat | output | LEN_W | Beat index |
| pay_last | output | 1 | Final beat of the payload |

## Verification
On every cycle, the assertions check the following:
- the grant is one-hot;
- a granted request was eligible;
- no low-class grant happens while a high-class request is eligible;
- no grant happens during a transfer;
- a stream starts at beat 0 and stays steady under back-pressure.

Other behaviour shows only in the bench's scenarios, where a behavioural model runs alongside:
- the exact rotation order and the pointers that stay put on a full array;
- which core and slot each thread lands in;
- that stray terminations change nothing;
- that exactly 60 threads fit.

// File: rtl/td_pkg.sv
package td_pkg;
    localparam int NSRC  = 4;
    localparam int PTR_W = 2;

    typedef enum logic [1:0] {
        KIND_VERTEX = 2'd0,
        KIND_GEOM   = 2'd1,
        KIND_PIXEL  = 2'd2,
        KIND_MEDIA  = 2'd3
    } src_kind_e;

    function automatic int core_count(input bit reduced);
        return reduced ? 6 : 12;
    endfunction

    function automatic int slot_count(input bit reduced);
        return reduced ? 4 : 5;
    endfunction
endpackage

// File: rtl/td_ready_gate.sv
module td_ready_gate #(
    parameter int AVAIL_W = 4,
    parameter int LEN_W   = 4
) (
    input  logic [td_pkg::NSRC*AVAIL_W-1:0] src_avail,
    input  logic [td_pkg::NSRC*LEN_W-1:0]   src_len,
    output logic [td_pkg::NSRC-1:0]         ready
);
    for (genvar s = 0; s < td_pkg::NSRC; s++) begin : g_src
        logic [AVAIL_W-1:0] av;
        logic [LEN_W-1:0]   ln;
        logic               has_len;
        assign av      = src_avail[s*AVAIL_W +: AVAIL_W];
        assign ln      = src_len[s*LEN_W +: LEN_W];
        assign has_len = (ln != '0);
        if (s == int'(td_pkg::KIND_VERTEX)) begin : g_vtx
            assign ready[s] = has_len && (int'(av) >= 2);
        end else if (s == int'(td_pkg::KIND_GEOM)) begin : g_geo
            assign ready[s] = has_len && (int'(av) >= int'(ln));
        end else if (s == int'(td_pkg::KIND_PIXEL)) begin : g_pix
            assign ready[s] = ((int'(ln) == 2) || (int'(ln) == 4) || (int'(ln) == 8))
                              && (int'(av) >= int'(ln));
        end else begin : g_med
            assign ready[s] = has_len && (av != '0);
        end
    end
endmodule

// File: rtl/td_rr_pick.sv
module td_rr_pick #(
    parameter int N     = 4,
    parameter int PTR_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [PTR_W-1:0] ptr,
    output logic             found,
    output logic [PTR_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int cand;
            cand = (int'(ptr) + k) % N;
            if (req[cand]) begin
                found = 1'b1;
                idx   = PTR_W'(cand);
            end
        end
    end
endmodule

// File: rtl/td_slot_find.sv
module td_slot_find #(
    parameter int NCORE  = 12,
    parameter int NSLOT  = 5,
    parameter int CORE_W = 4,
    parameter int SLOT_W = 3
) (
    input  logic [NCORE*NSLOT-1:0] busy,
    output logic                   found,
    output logic [CORE_W-1:0]      core,
    output logic [SLOT_W-1:0]      slot
);
    logic [NCORE-1:0]  core_free;
    logic [SLOT_W-1:0] first_slot [NCORE];

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NSLOT-1:0] free_v;
        assign free_v       = ~busy[c*NSLOT +: NSLOT];
        assign core_free[c] = |free_v;
        always_comb begin
            first_slot[c] = '0;
            for (int s = NSLOT - 1; s >= 0; s--) begin
                if (free_v[s]) first_slot[c] = SLOT_W'(s);
            end
        end
    end

    always_comb begin
        found = 1'b0;
        core  = '0;
        slot  = '0;
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (core_free[c]) begin
                found = 1'b1;
                core  = CORE_W'(c);
                slot  = first_slot[c];
            end
        end
    end
endmodule

// File: rtl/td_dispatch.sv
module td_dispatch #(
    parameter bit  REDUCED = 1'b0,
    parameter int  AVAIL_W = 4,
    parameter int  LEN_W   = 4,
    localparam int NCORE   = td_pkg::core_count(REDUCED),
    localparam int NSLOT   = td_pkg::slot_count(REDUCED),
    localparam int CORE_W  = $clog2(NCORE),
    localparam int SLOT_W  = $clog2(NSLOT)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [td_pkg::NSRC-1:0]         src_valid,
    input  logic [td_pkg::NSRC-1:0]         src_high,
    input  logic [td_pkg::NSRC*AVAIL_W-1:0] src_avail,
    input  logic [td_pkg::NSRC*LEN_W-1:0]   src_len,
    output logic [td_pkg::NSRC-1:0]         src_grant,
    input  logic                            term_valid,
    input  logic [CORE_W-1:0]               term_core,
    input  logic [SLOT_W-1:0]               term_slot,
    output logic                            pay_valid,
    input  logic                            pay_ready,
    output logic [td_pkg::PTR_W-1:0]        pay_src,
    output logic [CORE_W-1:0]               pay_core,
    output logic [SLOT_W-1:0]               pay_slot,
    output logic [LEN_W-1:0]                pay_beat,
    output logic                            pay_last
);
    import td_pkg::*;

    localparam int NTHR = NCORE * NSLOT;

    typedef struct packed {
        logic [NTHR-1:0]   busy;
        logic [PTR_W-1:0]  rr_hi;
        logic [PTR_W-1:0]  rr_lo;
        logic              xfer;
        logic [PTR_W-1:0]  src;
        logic [CORE_W-1:0] core;
        logic [SLOT_W-1:0] slot;
        logic [LEN_W-1:0]  beat;
        logic [LEN_W-1:0]  len;
    } state_t;

    state_t st_q, st_d;

    logic [NSRC-1:0]   ready, hi_req, lo_req;
    logic              hi_found, lo_found, free_found;
    logic [PTR_W-1:0]  hi_idx, lo_idx;
    logic [CORE_W-1:0] free_core;
    logic [SLOT_W-1:0] free_slot;

    td_ready_gate #(.AVAIL_W(AVAIL_W), .LEN_W(LEN_W)) u_gate (
        .src_avail(src_avail), .src_len(src_len), .ready(ready)
    );

    assign hi_req = ready & src_valid & src_high;
    assign lo_req = ready & src_valid & ~src_high;

    td_rr_pick #(.N(NSRC), .PTR_W(PTR_W)) u_pick_hi (
        .req(hi_req), .ptr(st_q.rr_hi), .found(hi_found), .idx(hi_idx)
    );
    td_rr_pick #(.N(NSRC), .PTR_W(PTR_W)) u_pick_lo (
        .req(lo_req), .ptr(st_q.rr_lo), .found(lo_found), .idx(lo_idx)
    );

    td_slot_find #(.NCORE(NCORE), .NSLOT(NSLOT), .CORE_W(CORE_W), .SLOT_W(SLOT_W)) u_find (
        .busy(st_q.busy), .found(free_found), .core(free_core), .slot(free_slot)
    );

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (int'(p) == NSRC - 1) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        logic             can_go;
        logic             go;
        logic [PTR_W-1:0] win;
        st_d      = st_q;
        src_grant = '0;
        can_go    = !st_q.xfer && free_found;
        go        = can_go && (hi_found || lo_found);
        win       = hi_found ? hi_idx : lo_idx;

        // payload stream progress
        if (st_q.xfer && pay_ready) begin
            if (st_q.beat == st_q.len - LEN_W'(1)) st_d.xfer = 1'b0;
            else                                   st_d.beat = st_q.beat + LEN_W'(1);
        end

        // termination frees a slot (out-of-range names ignored)
        if (term_valid && (int'(term_core) < NCORE) && (int'(term_slot) < NSLOT)) begin
            st_d.busy[int'(term_core) * NSLOT + int'(term_slot)] = 1'b0;
        end

        if (go) begin
            src_grant[win] = 1'b1;
            if (hi_found) st_d.rr_hi = next_ptr(hi_idx);
            else          st_d.rr_lo = next_ptr(lo_idx);
            st_d.busy[int'(free_core) * NSLOT + int'(free_slot)] = 1'b1;
            st_d.xfer = 1'b1;
            st_d.src  = win;
            st_d.core = free_core;
            st_d.slot = free_slot;
            st_d.beat = '0;
            st_d.len  = src_len[int'(win)*LEN_W +: LEN_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pay_valid = st_q.xfer;
    assign pay_src   = st_q.src;
    assign pay_core  = st_q.core;
    assign pay_slot  = st_q.slot;
    assign pay_beat  = st_q.beat;
    assign pay_last  = st_q.xfer && (st_q.beat == st_q.len - LEN_W'(1));
endmodule

// File: rtl/td_dispatch_chk.sv
module td_dispatch_chk #(
    parameter bit  REDUCED = 1'b0,
    parameter int  AVAIL_W = 4,
    parameter int  LEN_W   = 4,
    localparam int CORE_W  = $clog2(td_pkg::core_count(REDUCED)),
    localparam int SLOT_W  = $clog2(td_pkg::slot_count(REDUCED))
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [td_pkg::NSRC-1:0]         src_valid,
    input logic [td_pkg::NSRC-1:0]         src_high,
    input logic [td_pkg::NSRC*AVAIL_W-1:0] src_avail,
    input logic [td_pkg::NSRC*LEN_W-1:0]   src_len,
    input logic [td_pkg::NSRC-1:0]         src_grant,
    input logic                            pay_valid,
    input logic                            pay_ready,
    input logic [td_pkg::PTR_W-1:0]        pay_src,
    input logic [CORE_W-1:0]               pay_core,
    input logic [SLOT_W-1:0]               pay_slot,
    input logic [LEN_W-1:0]                pay_beat,
    input logic                            pay_last
);
    // independent statement of the per-kind eligibility rule
    function automatic logic [3:0] elig(input logic [4*AVAIL_W-1:0] av,
                                        input logic [4*LEN_W-1:0] ln);
        logic [3:0] r;
        for (int s = 0; s < 4; s++) begin
            int a, l;
            a = int'(av[s*AVAIL_W +: AVAIL_W]);
            l = int'(ln[s*LEN_W +: LEN_W]);
            case (s)
                0:       r[s] = (l > 0) && (a > 1);
                1:       r[s] = (l > 0) && (a >= l);
                2:       r[s] = (l == 2 || l == 4 || l == 8) && (a >= l);
                default: r[s] = (l > 0) && (a > 0);
            endcase
        end
        return r;
    endfunction

    logic [3:0] ok_req;
    assign ok_req = elig(src_avail, src_len) & src_valid;

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_grant));

    p_idle_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_grant != '0) |-> !pay_valid);

    p_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_grant & ~ok_req) == '0);

    p_high_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_grant & ~src_high) != '0) |-> ((ok_req & src_high) == '0));

    p_first_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_grant != '0) |=> (pay_valid && (pay_beat == '0)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && !pay_ready) |=> (pay_valid && $stable(pay_beat) && $stable(pay_core)
                                       && $stable(pay_slot) && $stable(pay_src)
                                       && $stable(pay_last)));

    p_stream_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && pay_ready && pay_last) |=> !pay_valid);
endmodule

bind td_dispatch td_dispatch_chk #(.REDUCED(REDUCED), .AVAIL_W(AVAIL_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/td_dispatch_tb_top.sv
module td_dispatch_tb_top;
    localparam int NC = 12;
    localparam int NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_valid = '0, src_high = '0, src_grant;
    logic [15:0] src_avail = '0, src_len = '0;
    logic        term_valid = 1'b0;
    logic [3:0]  term_core = '0;
    logic [2:0]  term_slot = '0;
    logic        pay_valid, pay_ready = 1'b1, pay_last;
    logic [1:0]  pay_src;
    logic [3:0]  pay_core, pay_beat;
    logic [2:0]  pay_slot;

    always #2.5 clk = ~clk;

    td_dispatch dut_i (.*);

    int vectors = 0, miscompares = 0, gcount = 0;
    bit done = 1'b0;
    logic [3:0] last_g = '0;
    int first_core = -1, first_slot = -1;

    // behavioural reference state
    bit mb [NC][NS];
    int rr_hi = 0, rr_lo = 0;
    bit mx = 0;
    int msrc = 0, mcore = 0, mslot = 0, mbeat = 0, mlen = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mready(input int s);
        int a, l;
        a = int'(src_avail[s*4 +: 4]);
        l = int'(src_len[s*4 +: 4]);
        if (s == 0) return (l >= 1) && (a >= 2);
        if (s == 1) return (l >= 1) && (a >= l);
        if (s == 2) return (l == 2 || l == 4 || l == 8) && (a >= l);
        return (l >= 1) && (a >= 1);
    endfunction

    // compare on every cycle away from the active edge, then advance model
    always @(negedge clk) if (rst_n && !done) begin
        int win, fc, fs;
        bit any_free, hi;
        logic [3:0] eg;
        eg = '0; win = -1; hi = 0; any_free = 0; fc = 0; fs = 0;
        for (int c = NC - 1; c >= 0; c--)
            for (int s = NS - 1; s >= 0; s--)
                if (!mb[c][s]) begin any_free = 1; fc = c; fs = s; end
        if (!mx && any_free) begin
            for (int k = 3; k >= 0; k--) begin
                int q;
                q = (rr_hi + k) % 4;
                if (src_valid[q] && src_high[q] && mready(q)) begin win = q; hi = 1; end
            end
            if (win < 0)
                for (int k = 3; k >= 0; k--) begin
                    int q;
                    q = (rr_lo + k) % 4;
                    if (src_valid[q] && !src_high[q] && mready(q)) win = q;
                end
        end
        if (win >= 0) eg[win] = 1'b1;
        check(src_grant == eg, "R2 R3 R4 R5 R7 grant", int'(src_grant), int'(eg));
        check(pay_valid == mx, "R8 pay_valid", int'(pay_valid), int'(mx));
        if (mx && pay_valid) begin
            check(int'(pay_src) == msrc, "R4 pay_src", int'(pay_src), msrc);
            check(int'(pay_core) == mcore, "R6 pay_core", int'(pay_core), mcore);
            check(int'(pay_slot) == mslot, "R6 pay_slot", int'(pay_slot), mslot);
            check(int'(pay_beat) == mbeat, "R8 pay_beat", int'(pay_beat), mbeat);
            check(pay_last == (mbeat == mlen - 1), "R8 pay_last", int'(pay_last), int'(mbeat == mlen - 1));
            if (mbeat == 0 && first_core < 0) begin first_core = mcore; first_slot = mslot; end
        end
        last_g = src_grant;
        if (src_grant != '0) gcount++;
        // next state
        if (mx && pay_ready) begin
            if (mbeat == mlen - 1) mx = 0; else mbeat++;
        end
        if (term_valid && term_core < NC && term_slot < NS) mb[term_core][term_slot] = 0;
        if (win >= 0) begin
            if (hi) rr_hi = (win + 1) % 4; else rr_lo = (win + 1) % 4;
            mb[fc][fs] = 1; mx = 1; msrc = win; mcore = fc; mslot = fs; mbeat = 0;
            mlen = int'(src_len[win*4 +: 4]);
        end
    end

    task automatic step();
        @(posedge clk); #1;
        src_valid  = src_valid & ~last_g;
        term_valid = 1'b0;
    endtask

    task automatic put(input int s, input bit h, input int av, input int ln);
        src_valid[s]      = 1'b1;
        src_high[s]       = h;
        src_avail[s*4+:4] = 4'(av);
        src_len[s*4+:4]   = 4'(ln);
    endtask

    task automatic term(input int c, input int s);
        term_valid = 1'b1; term_core = 4'(c); term_slot = 3'(s);
        step();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int g0, beats;
        logic [3:0] seen;
        repeat (3) @(posedge clk);
        #1;
        check(src_grant == '0 && pay_valid == 1'b0, "R1 reset outputs", int'(src_grant), 0);
        rst_n = 1'b1;
        step();
        check(pay_valid == 1'b0, "R1 idle after reset", int'(pay_valid), 0);

        // R2: vertex with one item waits, two items go
        put(0, 0, 1, 2);
        g0 = gcount;
        repeat (5) step();
        check(gcount == g0, "R2 vertex one item", gcount - g0, 0);
        put(0, 0, 2, 2);
        repeat (4) step();
        check(gcount == g0 + 1, "R2 vertex two items", gcount - g0, 1);

        // R2: pixel length 3 is not a legal quad count
        put(2, 0, 8, 3);
        g0 = gcount;
        repeat (5) step();
        check(gcount == g0, "R2 pixel bad quads", gcount - g0, 0);
        src_valid = '0;
        step();

        // R3: high pixel beats earlier-pointer low vertex
        put(0, 0, 3, 1); put(2, 1, 4, 4);
        step();
        check(last_g == 4'b0100 || (src_valid[2] == 1'b0), "R3 high wins", int'(last_g), 4);
        repeat (15) step();
        src_valid = '0;
        repeat (3) step();

        // R4: four low requests held, four grants all distinct
        seen = '0;
        for (int n = 0; n < 4; n++) begin
            put(0, 0, 2, 1); put(1, 0, 1, 1); put(2, 0, 2, 2); put(3, 0, 1, 1);
            while (last_g == '0) step();
            seen |= last_g;
            step();
        end
        check(seen == 4'hF, "R4 rotation covers all", int'(seen), 15);
        src_valid = '0;
        repeat (4) step();

        // R8: pixel eight quads under back-pressure
        put(2, 0, 8, 8);
        beats = 0;
        for (int n = 0; n < 80; n++) begin
            pay_ready = 1'(n % 3 != 0);
            @(negedge clk);
            if (pay_valid && pay_ready) beats++;
            step();
        end
        pay_ready = 1'b1;
        check(beats == 8, "R8 beat count", beats, 8);
        repeat (3) step();

        // free everything granted so far
        for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) term(c, s);

        // R10: fill the array with media threads
        g0 = gcount;
        for (int n = 0; n < 200; n++) begin put(3, 0, 1, 1); step(); end
        check(gcount - g0 == 60, "R10 capacity", gcount - g0, 60);
        // R7: full array grants nothing
        put(3, 0, 1, 1); put(1, 1, 2, 2);
        g0 = gcount;
        repeat (6) step();
        check(gcount == g0, "R7 full stall", gcount - g0, 0);
        // R9: stray terminations are ignored
        term(13, 0); term(2, 6);
        repeat (4) step();
        check(gcount == g0, "R9 stray term", gcount - g0, 0);
        // R9 R6: freeing core 5 slot 3 lets the high geometry request land there
        src_valid[3] = 1'b0;
        term(5, 3);
        first_core = -1;
        repeat (4) step();
        check(first_core == 5 && first_slot == 3, "R6 R9 reuse slot", first_core * 8 + first_slot, 43);
        src_valid = '0;
        for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) term(c, s);

        // mixed random traffic checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < 4; s++)
                if ($urandom_range(0, 2) == 0)
                    put(s, 1'($urandom_range(0, 1)), $urandom_range(0, 9), $urandom_range(0, 9));
            pay_ready = 1'($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0) begin
                term_valid = 1'b1;
                term_core  = 4'($urandom_range(0, 13));
                term_slot  = 3'($urandom_range(0, 6));
            end
            @(posedge clk); #1;
            src_valid = src_valid & ~last_g;
            if (term_valid) term_valid = 1'b0;
        end
        finish_run();
    end
endmodule